// File: doc/BRIEF.md
# Dual-Convention Host Bus Slave Interface

This block lets an 8-bit host processor reach a small register and memory space through one shared set of pins. The pins can follow either of two signalling conventions. A static strap input picks the convention. In the strobe convention, two active-low pins mark a write and a read. In the clocked convention, the same two pins carry an enable clock and a read/not-write level. An address strobe input captures the 11-bit address, so both multiplexed and non-multiplexed hosts work. The data bus, the acknowledge pin and the interrupt pin are each brought out as a value plus an output enable, so the pad ring can build the tristate drivers.

All host pins are sampled on the internal clock. A second static input sets how many sampling stages are used. The two-flop setting is for a host whose timing is unrelated to the internal clock. The single-flop setting is for a host whose timing is related to it. A core-side event input raises a pending interrupt flag. The host clears this flag by writing to a control byte, and the same byte sets the polarity of the interrupt pin.

Reset is filtered, so that only a reset held for several clock edges is recognised. While the reset pin is low, and whenever the test input is low, the outputs float.

Top module: `hbi_top`

## Requirements
- R1: With `moto_sel`=0 and `cs_n`=0, `strb_b`=0 performs a read and `strb_a`=0 (with `strb_b`=1) performs a write. Read data appears on `data_out` with `data_oe`=1 while the acknowledge is active. During a write, `data_oe` stays 0.
- R2: With `moto_sel`=1 and `cs_n`=0, `strb_a`=1 (enable clock high) starts an access. `strb_b`=1 makes it a read and `strb_b`=0 makes it a write.
- R3: `rdy_oe` is 1 while sampled `cs_n` is low. `rdy_out` is at its active level from the acknowledge cycle until the access ends. The active level is 1 for `moto_sel`=0 and 0 for `moto_sel`=1. `rdy_oe` is 0 once the host is idle.
- R4: The acknowledge appears 3 clock edges after the strobe pins change when `sync_sel`=1, and 2 edges after when `sync_sel`=0.
- R5: A sampled `ale`=1 captures `addr_in`. While `ale`=0, later changes on `addr_in` do not alter the address used by an access.
- R6: With `cs_n`=1, strobe activity causes no acknowledge, no data drive and no write.
- R7: Address 0 is the control byte. On a read it returns bit0 = interrupt polarity and bit1 = pending flag, with the other bits 0. Addresses 1 to 63 are memory bytes. Addresses 64 and above read as 0 and ignore writes.
- R8: A pulse on `irq_evt` sets the pending flag. `irq_out` equals the pending flag when the polarity bit is 1, and its inverse when the polarity bit is 0. Reset clears both the flag and the polarity bit. A write to address 0 sets the polarity from data bit0.
- R9: A write to address 0 with data bit1=1 clears the pending flag. If `irq_evt` is high on that same commit edge, the flag stays set.
- R10: Internal reset happens only when `rst_n` is sampled low on 4 consecutive clock edges. A shorter low pulse leaves the control and memory contents unchanged.
- R11: `data_oe` and `rdy_oe` are 0 in any cycle where `rst_n` is low.
- R12: When `test_n` is 0, `data_oe`, `rdy_oe` and `irq_oe` are all 0, whatever the rest of the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, filtered |
| test_n | input | 1 | Active-low float-all test input |
| moto_sel | input | 1 | Convention strap: 0 strobe pair, 1 enable clock plus read/not-write |
| sync_sel | input | 1 | 1 two-stage sampling, 0 single-stage sampling |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Write strobe (active low) or enable clock |
| strb_b | input | 1 | Read strobe (active low) or read/not-write level |
| ale | input | 1 | Address latch enable / address strobe |
| addr_in | input | 11 | Host address |
| data_in | input | 8 | Data bus, inbound half |
| data_out | output | 8 | Data bus, outbound half |
| data_oe | output | 1 | Data bus output enable |
| rdy_out | output | 1 | Ready / transfer-acknowledge level |
| rdy_oe | output | 1 | Ready / acknowledge output enable |
| irq_out | output | 1 | Interrupt level, polarity programmable |
| irq_oe | output | 1 | Interrupt output enable |
| irq_evt | input | 1 | Core-side interrupt event, synchronous to `clk` |

## Verification
Two functions can act on the pending flag in the same cycle. A core event can set it on the very edge where a host write to the control byte commits a clear. The bench lines this up by first asserting the write strobes. It then counts the sampling latency of the selected mode and raises `irq_evt` only across the commit edge. It judges the outcome from the pending bit read back through address 0, and from the level of the interrupt pin under the current polarity.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   typedef enum logic [1:0] {
      XFER_IDLE  = 2'd0,
      XFER_READ  = 2'd1,
      XFER_WRITE = 2'd2
   } xfer_e;

   localparam int unsigned CTRL_POL_BIT  = 0;
   localparam int unsigned CTRL_PEND_BIT = 1;

   // Maps the sampled pin levels to a transfer kind for either convention.
   function automatic xfer_e classify(input logic moto, input logic sel_n,
                                      input logic pin_a, input logic pin_b);
      xfer_e k;
      k = XFER_IDLE;
      if (!sel_n) begin
         if (moto) begin
            if (pin_a) k = pin_b ? XFER_READ : XFER_WRITE;
         end else begin
            if (!pin_b)      k = XFER_READ;
            else if (!pin_a) k = XFER_WRITE;
         end
      end
      return k;
   endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sel_long,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   generate
      if (STAGES == 1) begin : g_single
         assign q = stg[0];
      end else begin : g_chain
         assign q = sel_long ? stg[STAGES-1] : stg[0];
      end
   endgenerate

endmodule

// File: rtl/hbi_rst_filter.sv
module hbi_rst_filter #(
   parameter int unsigned HOLD = 4
) (
   input  logic clk,
   input  logic rst_n_pin,
   output logic rst
);

   logic [HOLD-1:0] hist;

   always_ff @(posedge clk) begin
      hist <= {hist[HOLD-2:0], rst_n_pin};
   end

   assign rst = ~|hist;

endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
   import hbi_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic moto,
   input  logic sel_n,
   input  logic pin_a,
   input  logic pin_b,
   output logic act_q,
   output logic rd_q,
   output logic sel_q,
   output logic start_rd,
   output logic start_wr
);

   xfer_e kind;
   logic  act;
   logic  first;

   assign kind     = classify(moto, sel_n, pin_a, pin_b);
   assign act      = (kind != XFER_IDLE);
   assign first    = act & ~act_q;
   assign start_rd = first & (kind == XFER_READ);
   assign start_wr = first & (kind == XFER_WRITE);

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         rd_q  <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         act_q <= act;
         sel_q <= ~sel_n;
         if (first) rd_q <= (kind == XFER_READ);
      end
   end

endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
   import hbi_pkg::*;
#(
   parameter int unsigned AW      = 11,
   parameter int unsigned DW      = 8,
   parameter int unsigned DEPTH   = 64,
   parameter bit          POL_RST = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          wr,
   input  logic          rd,
   input  logic          evt,
   output logic [DW-1:0] rdata_q,
   output logic          irq_lvl,
   output logic          pol,
   output logic          pend
);

   localparam int unsigned IW      = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_L = DEPTH[AW:0];

   logic [DW-1:0] mem [DEPTH];
   logic          hit_ctrl;
   logic          hit_mem;
   logic [IW-1:0] idx;
   logic          clr;
   logic [DW-1:0] rd_val;

   assign hit_ctrl = (addr == '0);
   assign hit_mem  = ({1'b0, addr} < DEPTH_L) && !hit_ctrl;
   assign idx      = addr[IW-1:0];
   assign clr      = wr & hit_ctrl & wdata[CTRL_PEND_BIT];

   always_comb begin
      rd_val = '0;
      if (hit_ctrl) begin
         rd_val[CTRL_POL_BIT]  = pol;
         rd_val[CTRL_PEND_BIT] = pend;
      end else if (hit_mem) begin
         rd_val = mem[idx];
      end
   end

   always_ff @(posedge clk) begin
      if (wr && hit_mem) mem[idx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pol     <= POL_RST;
         pend    <= 1'b0;
         rdata_q <= '0;
      end else begin
         pend <= evt | (pend & ~clr);
         if (wr && hit_ctrl) pol <= wdata[CTRL_POL_BIT];
         if (rd) rdata_q <= rd_val;
      end
   end

   assign irq_lvl = pol ? pend : ~pend;

endmodule

// File: rtl/hbi_top.sv
module hbi_top #(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MEM_DEPTH   = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_HOLD    = 4,
   parameter bit          IRQ_POL_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_n,
   input  logic              moto_sel,
   input  logic              sync_sel,
   input  logic              cs_n,
   input  logic              strb_a,
   input  logic              strb_b,
   input  logic              ale,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              rdy_out,
   output logic              rdy_oe,
   output logic              irq_out,
   output logic              irq_oe,
   input  logic              irq_evt
);

   localparam int unsigned SW = 4 + ADDR_W + DATA_W;

   initial begin
      if (MEM_DEPTH < 2 || MEM_DEPTH > (1 << ADDR_W))
         $error("hbi_top: MEM_DEPTH out of range");
      if (SYNC_STAGES < 2) $error("hbi_top: SYNC_STAGES must be at least 2");
      if (RST_HOLD < 2)    $error("hbi_top: RST_HOLD must be at least 2");
      if (DATA_W < 2)      $error("hbi_top: DATA_W must hold the control bits");
   end

   logic              rst_int;
   logic [SW-1:0]     smp;
   logic              s_cs_n, s_pa, s_pb, s_ale;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_din;
   logic [ADDR_W-1:0] latched_addr;
   logic [ADDR_W-1:0] eff_addr;
   logic              acc_act_q, acc_rd_q, acc_sel_q, start_rd, start_wr;
   logic [DATA_W-1:0] rdata_q;
   logic              irq_lvl, ctrl_pol, ctrl_pend;
   logic              drive_ok;

   hbi_rst_filter #(.HOLD(RST_HOLD)) u_rst (
      .clk       (clk),
      .rst_n_pin (rst_n),
      .rst       (rst_int)
   );

   hbi_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst_int),
      .sel_long (sync_sel),
      .rst_val  ({1'b1, {(SW-1){1'b0}}}),
      .d        ({cs_n, strb_a, strb_b, ale, addr_in, data_in}),
      .q        (smp)
   );

   assign {s_cs_n, s_pa, s_pb, s_ale, s_addr, s_din} = smp;

   always_ff @(posedge clk) begin
      if (rst_int)    latched_addr <= '0;
      else if (s_ale) latched_addr <= s_addr;
   end

   assign eff_addr = s_ale ? s_addr : latched_addr;

   hbi_decode u_dec (
      .clk      (clk),
      .rst      (rst_int),
      .moto     (moto_sel),
      .sel_n    (s_cs_n),
      .pin_a    (s_pa),
      .pin_b    (s_pb),
      .act_q    (acc_act_q),
      .rd_q     (acc_rd_q),
      .sel_q    (acc_sel_q),
      .start_rd (start_rd),
      .start_wr (start_wr)
   );

   hbi_regs #(
      .AW(ADDR_W), .DW(DATA_W), .DEPTH(MEM_DEPTH), .POL_RST(IRQ_POL_RST)
   ) u_regs (
      .clk     (clk),
      .rst     (rst_int),
      .addr    (eff_addr),
      .wdata   (s_din),
      .wr      (start_wr),
      .rd      (start_rd),
      .evt     (irq_evt),
      .rdata_q (rdata_q),
      .irq_lvl (irq_lvl),
      .pol     (ctrl_pol),
      .pend    (ctrl_pend)
   );

   assign drive_ok = test_n & rst_n & ~rst_int;
   assign data_out = rdata_q;
   assign data_oe  = drive_ok & acc_act_q & acc_rd_q;
   assign rdy_oe   = drive_ok & acc_sel_q;
   assign rdy_out  = acc_act_q ? ~moto_sel : moto_sel;
   assign irq_out  = irq_lvl;
   assign irq_oe   = test_n;

endmodule

// File: rtl/hbi_checks.sv
module hbi_checks #(
   parameter int unsigned AW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rst_int,
   input logic          test_n,
   input logic          moto_sel,
   input logic          irq_evt,
   input logic          data_oe,
   input logic          rdy_out,
   input logic          rdy_oe,
   input logic          irq_out,
   input logic          irq_oe,
   input logic          s_cs_n,
   input logic          s_ale,
   input logic          acc_act_q,
   input logic [AW-1:0] latched_addr,
   input logic          ctrl_pol,
   input logic          ctrl_pend
);

   // R12: test input floats every output
   a_r12_test_floats: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      !test_n |-> (!data_oe && !rdy_oe && !irq_oe));

   // R11: reset pin floats the data bus and the acknowledge
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         a_r11_reset_floats: assert (!data_oe && !rdy_oe);
      end
   end

   // R3: data is only driven alongside an active acknowledge
   a_r3_data_with_ack: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      data_oe |-> (rdy_oe && (rdy_out == !moto_sel)));

   // R6: a deselected sample never opens an access
   a_r6_no_access_unselected: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      s_cs_n |=> !acc_act_q);

   // R5: the held address stays put while the strobe is low
   a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      !s_ale |=> $stable(latched_addr));

   // R8: after an event the pin shows the asserted level of the current polarity
   a_r8_event_drives_irq: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      irq_evt |=> (irq_out == ctrl_pol));

   // R9: an event always leaves the flag set, even against a clear
   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n || rst_int)
      irq_evt |=> ctrl_pend);

endmodule

bind hbi_top hbi_checks #(.AW(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rst_int      (rst_int),
   .test_n       (test_n),
   .moto_sel     (moto_sel),
   .irq_evt      (irq_evt),
   .data_oe      (data_oe),
   .rdy_out      (rdy_out),
   .rdy_oe       (rdy_oe),
   .irq_out      (irq_out),
   .irq_oe       (irq_oe),
   .s_cs_n       (s_cs_n),
   .s_ale        (s_ale),
   .acc_act_q    (acc_act_q),
   .latched_addr (latched_addr),
   .ctrl_pol     (ctrl_pol),
   .ctrl_pend    (ctrl_pend)
);

// File: tb/hbi_top_test.sv
module hbi_top_test;

   logic        clk = 1'b0;
   logic        rst_n, test_n, moto_sel, sync_sel, cs_n, strb_a, strb_b, ale, irq_evt;
   logic [10:0] addr_in;
   logic [7:0]  data_in;
   logic [7:0]  data_out;
   logic        data_oe, rdy_out, rdy_oe, irq_out, irq_oe;

   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 1'b0;

   logic [7:0] mdl_mem [64];
   bit         mdl_pol, mdl_pend;

   always #2 clk = ~clk;

   hbi_top uut (
      .clk(clk), .rst_n(rst_n), .test_n(test_n), .moto_sel(moto_sel), .sync_sel(sync_sel),
      .cs_n(cs_n), .strb_a(strb_a), .strb_b(strb_b), .ale(ale), .addr_in(addr_in),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .rdy_out(rdy_out),
      .rdy_oe(rdy_oe), .irq_out(irq_out), .irq_oe(irq_oe), .irq_evt(irq_evt)
   );

   function automatic logic [7:0] exp_read(input logic [10:0] a);
      if (a == 0)  return {6'b0, mdl_pend, mdl_pol};
      if (a < 64)  return mdl_mem[a[5:0]];
      return 8'h00;
   endfunction

   function automatic void mdl_write(input logic [10:0] a, input logic [7:0] d);
      if (a == 0) begin
         mdl_pol = d[0];
         if (d[1]) mdl_pend = 1'b0;
      end else if (a < 64) begin
         mdl_mem[a[5:0]] = d;
      end
   endfunction

   function automatic int exp_lat();
      return sync_sel ? 3 : 2;
   endfunction

   function automatic logic ack_lvl();
      return moto_sel ? 1'b0 : 1'b1;
   endfunction

   function automatic logic exp_irq();
      return mdl_pol ? mdl_pend : ~mdl_pend;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      cs_n   = 1'b1;
      ale    = 1'b0;
      strb_a = moto_sel ? 1'b0 : 1'b1;
      strb_b = 1'b1;
   endtask

   task automatic drive_strobes(input bit wr);
      cs_n = 1'b0;
      if (moto_sel) begin
         strb_a = 1'b1;
         strb_b = !wr;
      end else begin
         strb_a = wr ? 1'b0 : 1'b1;
         strb_b = wr ? 1'b1 : 1'b0;
      end
   endtask

   // One host transfer; returns read data, data-enable and acknowledge latency.
   task automatic access(input bit wr, input logic [10:0] a, input logic [7:0] d,
                         input bit use_ale, output logic [7:0] rd,
                         output logic doe, output int lat);
      bit done;
      @(negedge clk);
      if (use_ale) begin
         addr_in = a;
         ale     = 1'b1;
      end
      data_in = d;
      drive_strobes(wr);
      lat  = 0;
      done = 1'b0;
      while (!done && lat < 12) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (rdy_oe && rdy_out == ack_lvl()) done = 1'b1;
      end
      rd  = data_out;
      doe = data_oe;
      go_idle();
      repeat (5) @(posedge clk);
   endtask

   task automatic do_write(input string req, input logic [10:0] a, input logic [7:0] d);
      logic [7:0] rd;
      logic doe;
      int lat;
      access(1'b1, a, d, 1'b1, rd, doe, lat);
      chk({req, " write no data drive"}, {31'b0, doe}, 32'd0);
      mdl_write(a, d);
   endtask

   task automatic do_read(input string req, input logic [10:0] a);
      logic [7:0] rd;
      logic doe;
      int lat;
      access(1'b0, a, 8'h00, 1'b1, rd, doe, lat);
      chk({req, " read data"}, {24'b0, rd}, {24'b0, exp_read(a)});
      chk({req, " read enable"}, {31'b0, doe}, 32'd1);
   endtask

   task automatic pulse_evt();
      @(negedge clk);
      irq_evt = 1'b1;
      @(negedge clk);
      irq_evt = 1'b0;
      mdl_pend = 1'b1;
   endtask

   task automatic random_phase(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         logic [10:0] a;
         logic [7:0]  d;
         int sel;
         sel = $urandom % 10;
         if (sel == 0)      a = 11'd0;
         else if (sel == 1) a = 11'(64 + ($urandom % 1984));
         else               a = 11'(1 + ($urandom % 63));
         d = 8'($urandom);
         if ($urandom % 2) do_write(req, a, d);
         else              do_read(req, a);
         if ($urandom % 4 == 0) begin
            pulse_evt();
            chk("R8 irq after random event", {31'b0, irq_out}, {31'b0, exp_irq()});
         end
      end
   endtask

   task automatic set_mode(input bit moto, input bit sync);
      @(negedge clk);
      moto_sel = moto;
      sync_sel = sync;
      go_idle();
      repeat (5) @(posedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic doe;
      int lat;
      void'($urandom(32'd4711));
      rst_n = 1'b0; test_n = 1'b1; moto_sel = 1'b0; sync_sel = 1'b1;
      irq_evt = 1'b0; addr_in = '0; data_in = '0;
      go_idle();
      mdl_pol = 1'b0; mdl_pend = 1'b0;
      for (int i = 0; i < 64; i++) mdl_mem[i] = 8'h00;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 data float during reset", {31'b0, data_oe}, 32'd0);
      chk("R11 ack float during reset", {31'b0, rdy_oe}, 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R3 reset ack idle", {31'b0, rdy_oe}, 32'd0);
      chk("R8 reset irq level", {31'b0, irq_out}, 32'd1);
      chk("R12 irq driven normally", {31'b0, irq_oe}, 32'd1);

      // R1: fill memory in the strobe convention
      for (int i = 1; i < 64; i++) do_write("R1", 11'(i), 8'(i * 37 + 5));
      do_read("R1", 11'd1);
      do_read("R1", 11'd63);

      // R4: acknowledge latency in each sampling mode
      access(1'b0, 11'd10, 8'h00, 1'b1, rd, doe, lat);
      chk("R4 latency two-stage", lat, 32'd3);
      set_mode(1'b0, 1'b0);
      access(1'b0, 11'd10, 8'h00, 1'b1, rd, doe, lat);
      chk("R4 latency one-stage", lat, 32'd2);
      chk("R1 read value one-stage", {24'b0, rd}, {24'b0, exp_read(11'd10)});

      // R2: clocked convention
      set_mode(1'b1, 1'b1);
      do_write("R2", 11'd20, 8'h5A);
      do_read("R2", 11'd20);
      access(1'b0, 11'd20, 8'h00, 1'b1, rd, doe, lat);
      chk("R4 latency clocked two-stage", lat, 32'd3);
      @(negedge clk);
      chk("R3 ack released after access", {31'b0, rdy_oe}, 32'd0);

      // R5: held address used after strobe drops
      @(negedge clk);
      addr_in = 11'd5; ale = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      ale = 1'b0; addr_in = 11'd9;
      repeat (3) @(posedge clk);
      access(1'b1, 11'd0, 8'hA5, 1'b0, rd, doe, lat);
      mdl_write(11'd5, 8'hA5);
      do_read("R5 latched target", 11'd5);
      do_read("R5 pin address untouched", 11'd9);

      // R6: chip select high blocks everything
      @(negedge clk);
      cs_n = 1'b1; addr_in = 11'd7; ale = 1'b1; data_in = 8'h3C;
      strb_a = 1'b1; strb_b = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R6 no ack when deselected", {31'b0, rdy_oe}, 32'd0);
      chk("R6 no data when deselected", {31'b0, data_oe}, 32'd0);
      go_idle();
      repeat (5) @(posedge clk);
      do_read("R6 location unchanged", 11'd7);

      // R7: map boundaries
      do_write("R7", 11'd64, 8'hEE);
      do_read("R7 out of range", 11'd64);
      do_write("R7", 11'd2047, 8'h11);
      do_read("R7 top of space", 11'd2047);
      do_read("R7 mirror check", 11'd0);

      // R8: polarity and pending flag
      pulse_evt();
      chk("R8 low-active asserted", {31'b0, irq_out}, 32'd0);
      do_write("R8", 11'd0, 8'h01);
      chk("R8 high-active asserted", {31'b0, irq_out}, 32'd1);
      do_read("R8 control readback", 11'd0);
      do_write("R9", 11'd0, 8'h03);
      chk("R9 cleared flag", {31'b0, irq_out}, 32'd0);

      // R9: clear and event on the same commit edge
      set_mode(1'b0, 1'b1);
      pulse_evt();
      @(negedge clk);
      addr_in = 11'd0; ale = 1'b1; data_in = 8'h02;
      drive_strobes(1'b1);
      repeat (exp_lat() - 1) @(posedge clk);
      @(negedge clk);
      irq_evt = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_evt = 1'b0;
      chk("R9 ack on commit edge", {31'b0, rdy_out}, {31'b0, ack_lvl()});
      mdl_pol = 1'b0;
      mdl_pend = 1'b1;
      go_idle();
      repeat (5) @(posedge clk);
      do_read("R9 event beats clear", 11'd0);
      chk("R9 irq still asserted", {31'b0, irq_out}, {31'b0, exp_irq()});

      // R11 and R12: floating mid-read
      @(negedge clk);
      addr_in = 11'd1; ale = 1'b1;
      drive_strobes(1'b0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R11 driving before reset pin", {31'b0, data_oe}, 32'd1);
      rst_n = 1'b0;
      #1;
      chk("R11 data float on reset pin", {31'b0, data_oe}, 32'd0);
      chk("R11 ack float on reset pin", {31'b0, rdy_oe}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 access survives short reset", {31'b0, data_oe}, 32'd1);
      test_n = 1'b0;
      #1;
      chk("R12 data float", {31'b0, data_oe}, 32'd0);
      chk("R12 ack float", {31'b0, rdy_oe}, 32'd0);
      chk("R12 irq float", {31'b0, irq_oe}, 32'd0);
      @(negedge clk);
      test_n = 1'b1;
      go_idle();
      repeat (5) @(posedge clk);

      // R10: reset filter
      do_write("R10", 11'd0, 8'h01);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      do_read("R10 three-edge pulse ignored", 11'd0);
      do_read("R10 memory kept", 11'd20);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      mdl_pol = 1'b0;
      mdl_pend = 1'b0;
      do_read("R10 four-edge reset taken", 11'd0);
      chk("R10 irq after reset", {31'b0, irq_out}, 32'd1);

      // Random traffic across all four configurations
      set_mode(1'b0, 1'b1); random_phase("R1 random", 40);
      set_mode(1'b0, 1'b0); random_phase("R1 random", 40);
      set_mode(1'b1, 1'b1); random_phase("R2 random", 40);
      set_mode(1'b1, 1'b0); random_phase("R2 random", 40);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule